// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Masked Status Flags

This block is the data path of a small eight-bit microcontroller core. Each cycle it may receive one operation code and two operands. An operand is either a register value or an immediate. The block computes the result combinationally and reports whether the result should be written back. It also produces new values for six status flags, together with a mask that names the flags the operation is allowed to change. The flags are held in a register inside the block. On the clock edge that ends an issued operation, only the masked flags take their new values, and all the others keep their old state.

The operation set covers:
- add and subtract, each with and without carry;
- compare and compare-with-carry;
- bitwise AND, OR and XOR;
- one's and two's complement;
- increment and decrement;
- load of all ones;
- shift left, shift right, and rotate left through carry.

Immediate forms and aliases need no operation of their own. The caller places the immediate or a repeated register on the second operand. Examples are "test" (AND of a value with itself), "clear" (XOR with itself), and bit set or bit clear (OR, or AND with an inverted mask).

Subtract-with-carry and compare-with-carry chain the zero flag. A compare that spans several bytes therefore reports zero only when every byte matched.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes: ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, SER=13, LSL=14, LSR=15, ROL=16. Flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Z is set when the result is zero. N is the result's bit 7.
- R2: ADD returns a+b and ADC returns a+b+C. Both update Z, C, N, V, S and H. C is the carry out of bit 7, H is the carry out of bit 3, and V flags signed overflow.
- R3: SUB returns a-b and SBC returns a-b-C. Both update Z, C, N, V, S and H. C is the borrow out of bit 7, H is the borrow out of bit 3, and V flags signed overflow.
- R4: CMP and CPC update the flags exactly as SUB and SBC would, and they never assert res_we.
- R5: After SBC or CPC, Z is 1 only if Z was already 1 and the eight-bit result is zero.
- R6: AND, OR and XOR return the bitwise result. They update only Z, N, V and S, force V to 0, and leave C and H unchanged.
- R7: COM returns 0xFF-a. It forces C to 1 and V to 0, updates Z, N and S, and leaves H unchanged.
- R8: NEG returns 0x00-a and updates all six flags. C is 1 unless a is zero, V is 1 only for a=0x80, and H is the borrow out of bit 3.
- R9: INC returns a+1 and DEC returns a-1. Both update only Z, N, V and S, and leave C and H unchanged. V is 1 when INC starts at 0x7F or when DEC starts at 0x80.
- R10: LSL shifts left with 0 entering bit 0. LSR shifts right with 0 entering bit 7. ROL shifts left with the old C entering bit 0. C takes the bit shifted out. V equals N XOR C. Z, C, N, V and S are updated, and H is unchanged.
- R11: SER returns 0xFF, asserts res_we, and changes no flag.
- R12: The flags reset to 0. They change only on the rising clock edge that follows a cycle with issue high, and only in the bits set in flag_mask. While issue is low, res_we and flag_mask are 0.
- R13: The S flag always equals N XOR V.
- R14: The codes 17 to 31 return 0, never assert res_we, and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (R1) |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (register or immediate) |
| result | output | 8 | Combinational result |
| res_we | output | 1 | Result should be written back |
| flag_next | output | 6 | Candidate new flag values |
| flag_mask | output | 6 | Flags the operation updates |
| flags | output | 6 | Registered status flags |

## Verification
Directed operand pairs are chosen around the signed and unsigned limits: 0x7F+1, 0xFF+1, 0x80-1, 0-1 and equal operands. These separate carry from overflow and half-carry, and they also separate borrow from carry. The bench sets the carry flag up before the logic, increment and shift operations. A wrong update mask then shows as a lost or a changed C. Compare-with-carry chains are run with the zero flag first cleared and then set. This shows that Z can only fall across a chain. After the directed cases, several thousand random operations run through all 32 codes, with issue low in some cycles. Each one is checked against a behavioural integer model of every output and of the flag register.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [4:0] {
      OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
      OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
      OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
      OP_DEC = 5'd12, OP_SER = 5'd13, OP_LSL = 5'd14, OP_LSR = 5'd15,
      OP_ROL = 5'd16
   } alu_op_e;

   localparam int NFLAGS = 6;
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         hout,
   output logic         vout
);
   logic [W-1:0] yy;
   logic         ci;
   logic         cw;

   // subtraction as x + ~y + ~borrow; carries inverted back into borrows
   assign yy = sub ? ~y : y;
   assign ci = sub ? ~cin : cin;
   assign {cw, sum} = {1'b0, x} + {1'b0, yy} + (W+1)'(ci);
   assign cout = sub ? ~cw : cw;
   // carry into bit 4 recovered from the sum bit and its inputs
   assign hout = sub ? ~(x[4] ^ yy[4] ^ sum[4]) : (x[4] ^ yy[4] ^ sum[4]);
   assign vout = (x[W-1] == yy[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_shiftlogic.sv
module alu8_shiftlogic import alu8_pkg::*; #(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);
   always_comb begin
      res  = '0;
      cout = 1'b0;
      unique case (op)
         OP_AND: res = x & y;
         OP_OR:  res = x | y;
         OP_XOR: res = x ^ y;
         OP_COM: begin res = ~x; cout = 1'b1; end
         OP_LSL: begin res = {x[W-2:0], 1'b0}; cout = x[W-1]; end
         OP_LSR: begin res = {1'b0, x[W-1:1]}; cout = x[0]; end
         OP_ROL: begin res = {x[W-2:0], cin};  cout = x[W-1]; end
         OP_SER: res = '1;
         default: begin res = '0; cout = 1'b0; end
      endcase
   end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
   parameter int NF = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [NF-1:0] mask,
   input  logic [NF-1:0] nxt,
   output logic [NF-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= (q & ~mask) | (nxt & mask);
   end

   // R12: unmasked flags survive an update
   a_r12_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
   // R12: no update without an issued operation
   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags import alu8_pkg::*; #(
   parameter int DATA_W  = 8,
   parameter bit CHAIN_Z = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [4:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result,
   output logic              res_we,
   output logic [NFLAGS-1:0] flag_next,
   output logic [NFLAGS-1:0] flag_mask
   ,output logic [NFLAGS-1:0] flags
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
   localparam logic [NFLAGS-1:0] M_ALL   = 6'b111111;
   localparam logic [NFLAGS-1:0] M_ZNVS  = 6'b011110;
   localparam logic [NFLAGS-1:0] M_ZCNVS = 6'b011111;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("alu8_flags: DATA_W must be at least 8");
      end
   endgenerate

   alu_op_e op_e;
   assign op_e = alu_op_e'(op);

   logic cf, zf;
   assign cf = flags[FL_C];
   assign zf = flags[FL_Z];

   // ---------------- adder operand selection ----------------
   logic [DATA_W-1:0] as_x, as_y, as_sum;
   logic as_cin, as_sub, as_c, as_h, as_v;

   always_comb begin
      as_x = opa; as_y = opb; as_cin = 1'b0; as_sub = 1'b0;
      unique case (op_e)
         OP_ADC:         as_cin = cf;
         OP_SUB, OP_CMP: as_sub = 1'b1;
         OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = cf; end
         OP_NEG:         begin as_x = '0; as_y = opa; as_sub = 1'b1; end
         OP_INC:         as_y = ONE;
         OP_DEC:         begin as_y = ONE; as_sub = 1'b1; end
         default:        ;
      endcase
   end

   alu8_addsub #(.W(DATA_W)) u_addsub (
      .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
      .sum(as_sum), .cout(as_c), .hout(as_h), .vout(as_v));

   logic [DATA_W-1:0] sl_res;
   logic sl_c;

   alu8_shiftlogic #(.W(DATA_W)) u_shiftlogic (
      .op(op_e), .x(opa), .y(opb), .cin(cf), .res(sl_res), .cout(sl_c));

   // ---------------- zero flag, with optional chaining ----------------
   logic z_arith;
   generate
      if (CHAIN_Z) begin : g_chain_z
         assign z_arith = (as_sum == '0) &&
                          (((op_e != OP_SBC) && (op_e != OP_CPC)) || zf);
      end else begin : g_plain_z
         assign z_arith = (as_sum == '0);
      end
   endgenerate

   // ---------------- result, write enable, flags ----------------
   logic [NFLAGS-1:0] nf, msk;
   logic we_op;

   always_comb begin
      result = '0; we_op = 1'b0; msk = '0; nf = flags;
      unique case (op_e)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
            result   = as_sum;
            we_op    = (op_e != OP_CMP) && (op_e != OP_CPC);
            msk      = M_ALL;
            nf[FL_Z] = z_arith;
            nf[FL_C] = as_c;
            nf[FL_V] = as_v;
            nf[FL_H] = as_h;
         end
         OP_INC, OP_DEC: begin
            result   = as_sum;
            we_op    = 1'b1;
            msk      = M_ZNVS;
            nf[FL_Z] = (as_sum == '0);
            nf[FL_V] = as_v;
         end
         OP_AND, OP_OR, OP_XOR, OP_COM: begin
            result   = sl_res;
            we_op    = 1'b1;
            msk      = (op_e == OP_COM) ? M_ZCNVS : M_ZNVS;
            nf[FL_Z] = (sl_res == '0);
            nf[FL_C] = (op_e == OP_COM) ? sl_c : cf;
            nf[FL_V] = 1'b0;
         end
         OP_LSL, OP_LSR, OP_ROL: begin
            result   = sl_res;
            we_op    = 1'b1;
            msk      = M_ZCNVS;
            nf[FL_Z] = (sl_res == '0);
            nf[FL_C] = sl_c;
            nf[FL_V] = sl_res[DATA_W-1] ^ sl_c;
         end
         OP_SER: begin
            result = sl_res;
            we_op  = 1'b1;
         end
         default: ;
      endcase
      nf[FL_N] = result[DATA_W-1];
      nf[FL_S] = nf[FL_N] ^ nf[FL_V];
   end

   assign res_we    = issue & we_op;
   assign flag_mask = issue ? msk : '0;
   assign flag_next = nf;

   alu8_flagreg #(.NF(NFLAGS)) u_flagreg (
      .clk(clk), .rst_n(rst_n), .en(issue), .mask(flag_mask),
      .nxt(flag_next), .q(flags));

   // ---------------- assertions ----------------
   // R4: compares never write a result
   a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (op_e == OP_CMP || op_e == OP_CPC)) |-> !res_we);
   // R13: sign flag consistent with N and V
   a_r13_s_is_xor: assert property (@(posedge clk) disable iff (!rst_n)
      flags[FL_S] == (flags[FL_N] ^ flags[FL_V]));
   // R11: load of all ones leaves the flags alone
   a_r11_ser_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op_e == OP_SER) |=> $stable(flags));
   // R6: logic operations clear V
   a_r6_logic_v0: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR)) |=> !flags[FL_V]);
   // R7: complement sets carry
   a_r7_com_c: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op_e == OP_COM) |=> flags[FL_C]);
   // R9: increment and decrement keep C and H
   a_r9_incdec_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (op_e == OP_INC || op_e == OP_DEC)) |=>
         ($stable(flags[FL_C]) && $stable(flags[FL_H])));
   // R14: unused codes change nothing
   a_r14_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op > 5'd16) |=> $stable(flags));
   generate
      if (CHAIN_Z) begin : g_chain_chk
         // R5: Z can only fall across a carry-chained subtract or compare
         a_r5_chain_z: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && (op_e == OP_SBC || op_e == OP_CPC) && !flags[FL_Z]) |=> !flags[FL_Z]);
      end
   endgenerate
endmodule

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue = 1'b0;
   logic [4:0] op = '0;
   logic [7:0] opa = '0, opb = '0;
   logic [7:0] result;
   logic       res_we;
   logic [5:0] flag_next, flag_mask, flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [5:0] mflags = '0;
   string last_tag = "R12";

   always #2.5 clk = ~clk;

   alu8_flags uut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .opa(opa), .opb(opb),
      .result(result), .res_we(res_we), .flag_next(flag_next),
      .flag_mask(flag_mask), .flags(flags));

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int sx(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   function automatic string tag_of(input int o);
      case (o)
         0, 1:     return "R2";
         2, 3:     return "R3";
         4, 5:     return "R4";
         6, 7, 8:  return "R6";
         9:        return "R7";
         10:       return "R8";
         11, 12:   return "R9";
         13:       return "R11";
         14,15,16: return "R10";
         default:  return "R14";
      endcase
   endfunction

   // behavioural model: returns result, write flag, mask and computed flag values
   task automatic model(input int o, input int a, input int b, input logic [5:0] fin,
                        output int r, output int we, output logic [5:0] m, output logic [5:0] f);
      int t, sv, cin;
      logic c, z, v, h, n;
      c = fin[0]; z = 1'b0; v = fin[3]; h = fin[5];
      cin = fin[0] ? 1 : 0;
      r = 0; we = 1; m = 6'b000000;
      case (o)
         0, 1: begin
            if (o == 0) cin = 0;
            t = a + b + cin; r = t & 255; c = t > 255;
            h = ((a & 15) + (b & 15) + cin) > 15;
            sv = sx(a) + sx(b) + cin; v = (sv > 127) || (sv < -128);
            z = (r == 0); m = 6'b111111;
         end
         2, 3, 4, 5: begin
            if (o == 2 || o == 4) cin = 0;
            t = a - b - cin; r = t & 255; c = t < 0;
            h = ((a & 15) - (b & 15) - cin) < 0;
            sv = sx(a) - sx(b) - cin; v = (sv > 127) || (sv < -128);
            z = (r == 0) && ((o == 2 || o == 4) || fin[1]);
            we = (o < 4); m = 6'b111111;
         end
         6, 7, 8: begin
            r = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (a ^ b);
            v = 0; z = (r == 0); m = 6'b011110;
         end
         9: begin r = 255 - a; c = 1; v = 0; z = (r == 0); m = 6'b011111; end
         10: begin
            r = (256 - a) & 255; c = (a != 0); h = ((a & 15) != 0);
            v = (a == 128); z = (r == 0); m = 6'b111111;
         end
         11: begin r = (a + 1) & 255; v = (a == 127); z = (r == 0); m = 6'b011110; end
         12: begin r = (a + 255) & 255; v = (a == 128); z = (r == 0); m = 6'b011110; end
         13: begin r = 255; m = 6'b000000; end
         14, 15, 16: begin
            if (o == 14)      begin r = (a * 2) & 255;         c = a >= 128; end
            else if (o == 15) begin r = a / 2;                 c = (a % 2) == 1; end
            else              begin r = ((a * 2) & 255) + cin; c = a >= 128; end
            z = (r == 0); v = (r >= 128) ^ c; m = 6'b011111;
         end
         default: begin r = 0; we = 0; m = 6'b000000; end
      endcase
      n = (r >= 128);
      f = {h, n ^ v, v, n, z, c};
   endtask

   task automatic apply(input int o, input int a, input int b, input bit iss, input string tg);
      int r, we;
      logic [5:0] m, f;
      string t;
      @(negedge clk);
      check(last_tag, "flags register (R12)", flags, mflags);
      check("R13", "S equals N xor V", flags[4], flags[2] ^ flags[3]);
      op = 5'(o); opa = 8'(a); opb = 8'(b); issue = iss;
      #1;
      t = (tg == "") ? tag_of(o) : tg;
      model(o, a, b, mflags, r, we, m, f);
      check(t, "result", result, r);
      check(iss ? t : "R12", "res_we", res_we, iss ? we : 0);
      check(iss ? t : "R12", "flag_mask", flag_mask, iss ? m : 6'b0);
      check(t, "flag_next under mask", flag_next & m, f & m);
      if (iss) mflags = (mflags & ~m) | (f & m);
      last_tag = iss ? t : "R12";
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R12", "flags after reset", flags, 0);
      check("R12", "res_we idle", res_we, 0);
      rst_n = 1'b1;

      // R2: carry, half carry and overflow corners
      apply(0, 8'h7F, 8'h01, 1, "R2");
      apply(0, 8'hFF, 8'h01, 1, "R2");
      apply(1, 8'h10, 8'h0F, 1, "R2");     // C was set by previous add
      // R3: subtract corners
      apply(2, 8'h80, 8'h01, 1, "R3");
      apply(2, 8'h00, 8'h01, 1, "R3");
      apply(3, 8'h05, 8'h05, 1, "R3");     // borrow in from previous
      // R4 and R5: compare chains
      apply(4, 8'h12, 8'h13, 1, "R4");     // Z cleared, C set
      apply(5, 8'h34, 8'h33, 1, "R5");     // equal with borrow, Z must stay 0
      apply(4, 8'h22, 8'h22, 1, "R4");     // Z set, C clear
      apply(5, 8'h44, 8'h44, 1, "R5");     // Z stays 1
      apply(3, 8'h01, 8'h01, 1, "R5");
      // R6 with C set beforehand; R1 bit positions checked by register compare
      apply(2, 8'h00, 8'h01, 1, "R1");
      apply(6, 8'hF0, 8'h0F, 1, "R6");
      apply(7, 8'h80, 8'h01, 1, "R6");
      apply(8, 8'h5A, 8'h5A, 1, "R6");
      // R7, R8
      apply(9, 8'h00, 8'h00, 1, "R7");
      apply(10, 8'h80, 8'h00, 1, "R8");
      apply(10, 8'h00, 8'h00, 1, "R8");
      apply(10, 8'h01, 8'h00, 1, "R8");
      // R9 with C set
      apply(2, 8'h00, 8'h01, 1, "R3");
      apply(11, 8'h7F, 8'h00, 1, "R9");
      apply(12, 8'h80, 8'h00, 1, "R9");
      apply(12, 8'h01, 8'h00, 1, "R9");
      // R10 shifts
      apply(14, 8'h80, 8'h00, 1, "R10");
      apply(16, 8'h80, 8'h00, 1, "R10");  // C=1 rotates in
      apply(15, 8'h01, 8'h00, 1, "R10");
      apply(15, 8'hC2, 8'h00, 1, "R10");
      // R11, R14, R12
      apply(11, 8'h7F, 8'h00, 1, "R9");
      apply(13, 8'h12, 8'h00, 1, "R11");
      apply(20, 8'hFF, 8'h01, 1, "R14");
      apply(31, 8'h00, 8'h00, 1, "R14");
      apply(2, 8'h00, 8'h01, 0, "R12");

      for (int i = 0; i < 4000; i++) begin
         apply($urandom_range(31, 0), $urandom_range(255, 0), $urandom_range(255, 0),
               ($urandom_range(7, 0) != 0), "");
      end
      apply(13, 0, 0, 0, "R12");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule